// File: doc/BRIEF.md
# Test-Port Instruction Register with Mode Decoder

This block holds the instruction of a boundary-scan test port. An eight-bit shift stage sits between the serial data input and the instruction output pin. A second register sits behind it and holds the instruction that is in force. A test-port state machine outside the block drives strobes for capture, shift, update and test-logic-reset. From the code in force, a decoder selects which data register sits in the serial path and raises the mode controls that the boundary cells need.

When the shift stage captures, it loads the sample/preload code rather than the usual two-bit status pattern. Entering the capture state and passing straight to update therefore makes sample/preload active without shifting a single bit. Besides the standard instructions, the decoder knows two partial-chain sample codes and a partial-chain external-test code. These route the serial path through only the input cells or only the output cells.

The block also contains the two data registers whose contents never depend on the chip: a one-bit bypass stage and, when enabled by parameter, a 32-bit identification register. The boundary cells themselves live elsewhere.

Top module: `jtag_ir_decode`

## Requirements
- R1: A capture strobe loads the shift stage with 8'b1000_0001, so that ir_tdo reads 1 in the cycle after the capture edge.
- R2: A shift strobe moves the stage one place toward ir_tdo on each rising edge. ir_tdo always shows bit 0 and tdi enters at bit 7, so a code goes in least significant bit first.
- R3: The active instruction changes only on a falling clock edge while update_ir (or tlr, or rst) is high. Capture and shift strobes alone leave it unchanged.
- R4: A capture followed by an update with no shift makes 8'h81 (sample/preload) active. This selects the full boundary chain and raises no mode flag.
- R5: dr_sel encodes the selected register as 0 = bypass, 1 = identification, 2 = full chain, 3 = input-only chain, 4 = output-only chain. The codes that select them are 8'h00 and 8'h81 (full), 8'h41 (input only), 8'h42 and 8'h22 (output only), and 8'hAA (identification).
- R6: Every code outside {00, 81, 82, 03, 41, 42, 22, AA, FF} selects bypass and raises no mode flag.
- R7: extest_mode is high for codes 8'h00 and 8'h22. clamp_mode is high for 8'h82 and highz_mode is high for 8'h03. Both of the last two codes select bypass, and at most one flag is ever high.
- R8: While bypass is selected, a capture_dr loads the bypass bit with 0. Each shift_dr then moves tdi into it, so dr_tdo repeats tdi one cycle later.
- R9: While identification is selected, capture_dr loads {version[3:0], part[15:0], 11'b000_0000_1111, 1'b1}. Shifting puts it out on dr_tdo least significant bit first.
- R10: rst or tlr makes 8'hAA active when the identification register is present, and 8'hFF when it is not.
- R11: With the identification register left out (HAS_ID = 0), code 8'hAA selects bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | State machine is in test-logic-reset |
| capture_ir | input | 1 | Instruction capture strobe |
| shift_ir | input | 1 | Instruction shift strobe |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| tdi | input | 1 | Serial data in |
| ir_tdo | output | 1 | Serial out of the instruction shift stage |
| dr_tdo | output | 1 | Serial out of the bypass or identification register, 0 otherwise |
| active_ir | output | 8 | Instruction in force |
| dr_sel | output | 3 | Selected data register (encoding in R5) |
| extest_mode | output | 1 | Boundary outputs driven from update cells |
| clamp_mode | output | 1 | Outputs held from update cells while bypass is in path |
| highz_mode | output | 1 | All system outputs forced to high impedance |

## Verification
The bench builds two copies side by side from the same strobes. One has HAS_ID = 1 and part number 16'h5A3C. The other has HAS_ID = 0. Together they bring both reset defaults (R10) and the identification-code fallback to bypass (R11) within reach of a single run. The nonzero part number makes a shifted-out identification word with a misplaced field show up as a wrong value.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

    localparam int IR_W = 8;
    localparam int ID_W = 32;

    typedef logic [IR_W-1:0] ir_code_t;

    localparam ir_code_t OP_EXTEST   = 8'h00;
    localparam ir_code_t OP_SAMPLE   = 8'h81;
    localparam ir_code_t OP_CLAMP    = 8'h82;
    localparam ir_code_t OP_HIGHZ    = 8'h03;
    localparam ir_code_t OP_SAMP_IN  = 8'h41;
    localparam ir_code_t OP_SAMP_OUT = 8'h42;
    localparam ir_code_t OP_EXT_OUT  = 8'h22;
    localparam ir_code_t OP_IDENT    = 8'hAA;
    localparam ir_code_t OP_BYPASS   = 8'hFF;

    // pattern loaded by the capture strobe
    localparam ir_code_t IR_CAPTURE = OP_SAMPLE;

    typedef enum logic [2:0] {
        SEL_BYPASS    = 3'd0,
        SEL_IDENT     = 3'd1,
        SEL_CHAIN_ALL = 3'd2,
        SEL_CHAIN_IN  = 3'd3,
        SEL_CHAIN_OUT = 3'd4
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    extest;
        logic    clamp;
        logic    highz;
    } ir_ctl_t;

    function automatic ir_ctl_t decode_op(input ir_code_t op, input logic id_ok);
        ir_ctl_t c;
        c.sel    = SEL_BYPASS;
        c.extest = 1'b0;
        c.clamp  = 1'b0;
        c.highz  = 1'b0;
        case (op)
            OP_EXTEST:   begin c.sel = SEL_CHAIN_ALL; c.extest = 1'b1; end
            OP_SAMPLE:   c.sel = SEL_CHAIN_ALL;
            OP_CLAMP:    c.clamp = 1'b1;
            OP_HIGHZ:    c.highz = 1'b1;
            OP_SAMP_IN:  c.sel = SEL_CHAIN_IN;
            OP_SAMP_OUT: c.sel = SEL_CHAIN_OUT;
            OP_EXT_OUT:  begin c.sel = SEL_CHAIN_OUT; c.extest = 1'b1; end
            OP_IDENT:    c.sel = id_ok ? SEL_IDENT : SEL_BYPASS;
            default:     c.sel = SEL_BYPASS;
        endcase
        return c;
    endfunction

    function automatic logic [ID_W-1:0] make_id(input logic [3:0] ver,
                                                input logic [15:0] part,
                                                input logic [10:0] mfr);
        return {ver, part, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/jtag_ir_shift.sv
module jtag_ir_shift
    import irdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  logic     shift,
    input  logic     tdi,
    output ir_code_t sr_q,
    output logic     so
);
    ir_code_t sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= IR_CAPTURE;
        else if (capture)
            sr <= IR_CAPTURE;
        else if (shift)
            sr <= {tdi, sr[IR_W-1:1]};
    end

    assign sr_q = sr;
    assign so   = sr[0];
endmodule

// File: rtl/jtag_ir_latch.sv
module jtag_ir_latch
    import irdec_pkg::*;
#(
    parameter ir_code_t DEFAULT_OP = OP_IDENT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tlr,
    input  logic     update,
    input  ir_code_t d,
    output ir_code_t q
);
    ir_code_t held;

    // instruction in force changes on the falling edge only
    always_ff @(negedge clk) begin
        if (rst || tlr)
            held <= DEFAULT_OP;
        else if (update)
            held <= d;
    end

    assign q = held;
endmodule

// File: rtl/jtag_ir_decoder.sv
module jtag_ir_decoder
    import irdec_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  ir_code_t code,
    output ir_ctl_t  ctl
);
    always_comb begin
        ctl = decode_op(code, HAS_ID);
    end
endmodule

// File: rtl/jtag_fixed_dr.sv
module jtag_fixed_dr
    import irdec_pkg::*;
#(
    parameter bit            HAS_ID   = 1'b1,
    parameter logic [ID_W-1:0] ID_VALUE = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    input  logic sel_byp,
    input  logic sel_id,
    output logic tdo
);
    logic byp_q;
    logic id_so;

    always_ff @(posedge clk) begin
        if (rst)
            byp_q <= 1'b0;
        else if (sel_byp && capture)
            byp_q <= 1'b0;
        else if (sel_byp && shift)
            byp_q <= tdi;
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] id_q;
            always_ff @(posedge clk) begin
                if (rst)
                    id_q <= ID_VALUE;
                else if (sel_id && capture)
                    id_q <= ID_VALUE;
                else if (sel_id && shift)
                    id_q <= {tdi, id_q[ID_W-1:1]};
            end
            assign id_so = id_q[0];
        end else begin : g_no_id
            logic unused_id;
            assign unused_id = sel_id;
            assign id_so     = 1'b0;
        end
    endgenerate

    assign tdo = sel_byp ? byp_q : (sel_id ? id_so : 1'b0);
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
    import irdec_pkg::*;
#(
    parameter bit          HAS_ID     = 1'b1,
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [15:0] ID_PART    = 16'h5A3C,
    parameter logic [10:0] ID_MFR     = 11'b000_0000_1111
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tlr,
    input  logic       capture_ir,
    input  logic       shift_ir,
    input  logic       update_ir,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       tdi,
    output logic       ir_tdo,
    output logic       dr_tdo,
    output logic [7:0] active_ir,
    output logic [2:0] dr_sel,
    output logic       extest_mode,
    output logic       clamp_mode,
    output logic       highz_mode
);
    localparam ir_code_t        RESET_OP = HAS_ID ? OP_IDENT : OP_BYPASS;
    localparam logic [ID_W-1:0] ID_WORD  = make_id(ID_VERSION, ID_PART, ID_MFR);

    ir_code_t sr_val;
    ir_code_t cur_op;
    ir_ctl_t  ctl;

    jtag_ir_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .capture (capture_ir),
        .shift   (shift_ir),
        .tdi     (tdi),
        .sr_q    (sr_val),
        .so      (ir_tdo)
    );

    jtag_ir_latch #(.DEFAULT_OP(RESET_OP)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .tlr    (tlr),
        .update (update_ir),
        .d      (sr_val),
        .q      (cur_op)
    );

    jtag_ir_decoder #(.HAS_ID(HAS_ID)) u_dec (
        .code (cur_op),
        .ctl  (ctl)
    );

    jtag_fixed_dr #(.HAS_ID(HAS_ID), .ID_VALUE(ID_WORD)) u_fdr (
        .clk     (clk),
        .rst     (rst),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .sel_byp (ctl.sel == SEL_BYPASS),
        .sel_id  (ctl.sel == SEL_IDENT),
        .tdo     (dr_tdo)
    );

    assign active_ir   = cur_op;
    assign dr_sel      = ctl.sel;
    assign extest_mode = ctl.extest;
    assign clamp_mode  = ctl.clamp;
    assign highz_mode  = ctl.highz;
endmodule

// File: rtl/jtag_ir_decode_chk.sv
module jtag_ir_decode_chk #(
    parameter bit HAS_ID = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       tlr,
    input logic       capture_ir,
    input logic       update_ir,
    input logic       capture_dr,
    input logic       shift_dr,
    input logic       tdi,
    input logic       ir_tdo,
    input logic       dr_tdo,
    input logic [7:0] active_ir,
    input logic [2:0] dr_sel,
    input logic       extest_mode,
    input logic       clamp_mode,
    input logic       highz_mode
);
    localparam logic [7:0] DEF_OP = HAS_ID ? 8'hAA : 8'hFF;

    AST_CAPTURE_ONE: assert property (@(posedge clk) disable iff (rst)
        capture_ir |=> ir_tdo);  // R1

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!update_ir && !tlr) |-> $stable(active_ir));  // R3

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({extest_mode, clamp_mode, highz_mode}));  // R7

    AST_CLAMP_HIZ_BYP: assert property (@(posedge clk) disable iff (rst)
        (clamp_mode || highz_mode) |-> (dr_sel == 3'd0));  // R7

    AST_BYP_CAPT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && dr_sel == 3'd0 && !update_ir && !tlr) |=> !dr_tdo);  // R8

    AST_BYP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (shift_dr && !capture_dr && dr_sel == 3'd0 && !update_ir && !tlr)
        |=> dr_tdo == $past(tdi));  // R8

    AST_TLR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        tlr |-> active_ir == DEF_OP);  // R10
endmodule

bind jtag_ir_decode jtag_ir_decode_chk #(.HAS_ID(HAS_ID)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tlr         (tlr),
    .capture_ir  (capture_ir),
    .update_ir   (update_ir),
    .capture_dr  (capture_dr),
    .shift_dr    (shift_dr),
    .tdi         (tdi),
    .ir_tdo      (ir_tdo),
    .dr_tdo      (dr_tdo),
    .active_ir   (active_ir),
    .dr_sel      (dr_sel),
    .extest_mode (extest_mode),
    .clamp_mode  (clamp_mode),
    .highz_mode  (highz_mode)
);

// File: tb/jtag_ir_decode_tb_top.sv
`timescale 1ns/1ps
module jtag_ir_decode_tb_top;
    localparam logic [15:0] PART = 16'h5A3C;
    localparam logic [31:0] IDV  = {4'h0, PART, 11'b000_0000_1111, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1, tlr = 1'b0;
    logic cap_ir = 1'b0, sh_ir = 1'b0, up_ir = 1'b0;
    logic cap_dr = 1'b0, sh_dr = 1'b0, tdi = 1'b0;

    logic       ir_tdo, dr_tdo, ext, clp, hiz;
    logic [7:0] act;
    logic [2:0] sel;
    logic       ir_tdo_n, dr_tdo_n, ext_n, clp_n, hiz_n;
    logic [7:0] act_n;
    logic [2:0] sel_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    jtag_ir_decode #(.HAS_ID(1'b1), .ID_PART(PART)) dut_i (
        .clk(clk), .rst(rst), .tlr(tlr), .capture_ir(cap_ir), .shift_ir(sh_ir),
        .update_ir(up_ir), .capture_dr(cap_dr), .shift_dr(sh_dr), .tdi(tdi),
        .ir_tdo(ir_tdo), .dr_tdo(dr_tdo), .active_ir(act), .dr_sel(sel),
        .extest_mode(ext), .clamp_mode(clp), .highz_mode(hiz));

    jtag_ir_decode #(.HAS_ID(1'b0)) dut_noid (
        .clk(clk), .rst(rst), .tlr(tlr), .capture_ir(cap_ir), .shift_ir(sh_ir),
        .update_ir(up_ir), .capture_dr(cap_dr), .shift_dr(sh_dr), .tdi(tdi),
        .ir_tdo(ir_tdo_n), .dr_tdo(dr_tdo_n), .active_ir(act_n), .dr_sel(sel_n),
        .extest_mode(ext_n), .clamp_mode(clp_n), .highz_mode(hiz_n));

    // ---------------- behavioural reference ----------------
    // expected {sel[2:0], extest, clamp, highz}
    function automatic logic [5:0] expect_dec(input logic [7:0] op, input bit id_ok);
        case (op)
            8'h00: return {3'd2, 3'b100};
            8'h81: return {3'd2, 3'b000};
            8'h82: return {3'd0, 3'b010};
            8'h03: return {3'd0, 3'b001};
            8'h41: return {3'd3, 3'b000};
            8'h42: return {3'd4, 3'b000};
            8'h22: return {3'd4, 3'b100};
            8'hAA: return id_ok ? {3'd1, 3'b000} : {3'd0, 3'b000};
            default: return {3'd0, 3'b000};
        endcase
    endfunction

    logic [7:0]  m_sr;
    logic [7:0]  m_act, m_act_n;
    logic        m_byp, m_byp_n;
    bit          m_id_q[$];

    always @(posedge clk) begin
        logic [2:0] s, s_n;
        s   = expect_dec(m_act, 1'b1) >> 3;
        s_n = expect_dec(m_act_n, 1'b0) >> 3;
        if (rst) begin
            m_sr    <= 8'h81;
            m_byp   <= 1'b0;
            m_byp_n <= 1'b0;
            m_id_q.delete();
            for (int i = 0; i < 32; i++) m_id_q.push_back(IDV[i]);
        end else begin
            if (cap_ir)      m_sr <= 8'h81;
            else if (sh_ir)  m_sr <= {tdi, m_sr[7:1]};
            if (s == 3'd0) begin
                if (cap_dr)      m_byp <= 1'b0;
                else if (sh_dr)  m_byp <= tdi;
            end
            if (s_n == 3'd0) begin
                if (cap_dr)      m_byp_n <= 1'b0;
                else if (sh_dr)  m_byp_n <= tdi;
            end
            if (s == 3'd1) begin
                if (cap_dr) begin
                    m_id_q.delete();
                    for (int i = 0; i < 32; i++) m_id_q.push_back(IDV[i]);
                end else if (sh_dr) begin
                    void'(m_id_q.pop_front());
                    m_id_q.push_back(tdi);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst || tlr) begin
            m_act   <= 8'hAA;
            m_act_n <= 8'hFF;
        end else if (up_ir) begin
            m_act   <= m_sr;
            m_act_n <= m_sr;
        end
    end

    task automatic check(input string tag, input logic [31:0] actual,
                         input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
        end
    endtask

    // per-cycle comparison, sampled after both edges have settled
    always @(posedge clk) begin
        #4;
        if (!done) begin
            logic [5:0] d, dn;
            logic       exp_dr, exp_dr_n;
            d  = expect_dec(m_act, 1'b1);
            dn = expect_dec(m_act_n, 1'b0);
            exp_dr   = (d[5:3] == 3'd0) ? m_byp : (d[5:3] == 3'd1) ? m_id_q[0] : 1'b0;
            exp_dr_n = (dn[5:3] == 3'd0) ? m_byp_n : 1'b0;
            check("R2 ir_tdo", ir_tdo, m_sr[0]);
            check("R3 active_ir", act, m_act);
            check("R5 dr_sel", sel, d[5:3]);
            check("R7 flags", {ext, clp, hiz}, d[2:0]);
            check("R8/R9 dr_tdo", dr_tdo, exp_dr);
            check("R10 active_ir no-id", act_n, m_act_n);
            check("R11 dr_sel no-id", sel_n, dn[5:3]);
            check("R7 flags no-id", {ext_n, clp_n, hiz_n}, dn[2:0]);
            check("R8 dr_tdo no-id", dr_tdo_n, exp_dr_n);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input logic ci, input logic si, input logic ui,
                        input logic cd, input logic sd, input logic d);
        @(posedge clk);
        #1;
        cap_ir = ci; sh_ir = si; up_ir = ui; cap_dr = cd; sh_dr = sd; tdi = d;
    endtask

    task automatic idle_look();
        tick(0, 0, 0, 0, 0, 0);
        #3;
    endtask

    task automatic load_ir(input logic [7:0] op);
        tick(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            tick(0, 1, 0, 0, 0, op[i]);
            if (i == 0) begin
                #0.5;
                check("R1 capture pattern bit0", ir_tdo, 1'b1);
            end
        end
        tick(0, 0, 1, 0, 0, 0);
        idle_look();
    endtask

    initial begin
        logic [31:0] word;
        logic [7:0]  ops [12];
        ops = '{8'h00, 8'h81, 8'h82, 8'h03, 8'h41, 8'h42, 8'h22, 8'hAA,
                8'hFF, 8'h55, 8'h01, 8'h80};
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        idle_look();
        check("R10 reset default id", act, 8'hAA);
        check("R10 reset default no-id", act_n, 8'hFF);

        // capture straight to update
        tick(1, 0, 0, 0, 0, 0);
        tick(0, 0, 1, 0, 0, 0);
        idle_look();
        check("R4 capture-update active", act, 8'h81);
        check("R4 capture-update sel", sel, 3'd2);

        foreach (ops[k]) begin
            load_ir(ops[k]);
            check("R5 loaded code", act, ops[k]);
        end
        check("R6 unknown 80 sel", sel, 3'd0);

        load_ir(8'h82);
        check("R7 clamp flag", clp, 1'b1);
        // shift without update leaves the instruction in place
        tick(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) tick(0, 1, 0, 0, 0, 1'b1);
        idle_look();
        check("R3 hold without update", act, 8'h82);

        // bypass path
        load_ir(8'hFF);
        tick(0, 0, 0, 1, 0, 0);
        tick(0, 0, 0, 0, 1, 1);
        #0.5 check("R8 bypass captured zero", dr_tdo, 1'b0);
        tick(0, 0, 0, 0, 1, 0);
        #0.5 check("R8 bypass one-cycle delay", dr_tdo, 1'b1);
        idle_look();

        // identification word
        load_ir(8'hAA);
        check("R11 no-id sel bypass", sel_n, 3'd0);
        tick(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 32; i++) begin
            tick(0, 0, 0, 0, 1, 0);
            #0.5 word[i] = dr_tdo;
        end
        idle_look();
        check("R9 id word", word, IDV);

        // test-logic-reset
        load_ir(8'h41);
        tick(0, 0, 0, 0, 0, 0);
        tlr = 1'b1;
        idle_look();
        tlr = 1'b0;
        check("R10 tlr default id", act, 8'hAA);
        check("R10 tlr default no-id", act_n, 8'hFF);
        idle_look();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule